// File: doc/BRIEF.md
# Composite sync separator and coast generator

This block sits in front of a line-locked pixel clock loop. It watches a horizontal sync input that may carry composite sync, a separate vertical sync input and a sync-on-green slicer output, all already synchronous to the block clock. A broad pulse is told apart from an ordinary line pulse by its width: while the sync input is at its active level, a counter advances on a 5 MHz tick (200 ns per step), and once the count passes a programmed threshold the separated vertical sync output rises. The threshold is meant to be set above the widest line sync pulse.

From a chosen vertical sync source (the vertical sync pin or the separator output) the block builds a coast window. The window opens a programmed number of lines before vertical sync, covers the vertical sync interval, and closes a programmed number of lines after it. This lets the clock loop hold its frequency while line timing is disturbed. The line count of the previous frame is used to locate the opening point. Alternatively, an external coast pin with selectable polarity drives the coast output. Activity and detected-polarity flags for the sync inputs are reported alongside.

Top module: `csync_coast`

## Requirements
- R1: While reset is asserted and right after it, `sep_vs` and `coast` are 0, `sync_act` is 3'b000 and `sync_pol` is 3'b111 (every input is taken as active high until measured).
- R2: While the horizontal sync is at its active level, each cycle with `tick_5m` high adds one to a width count. Once that count exceeds `sep_thresh`, `sep_vs` goes to 1. It stays at 1 for the rest of the pulse and drops one clock after the level ends.
- R3: A pulse that spans a tick count equal to or below `sep_thresh` never raises `sep_vs`.
- R4: The active level used for width counting follows the detected horizontal sync polarity, so low-going pulses on an active-low input are measured the same way.
- R5: With `coast_sel_vs`=0, `coast` follows the coast pin one clock later. The pin is active when `coast_pin` equals `coast_pol` (1: active high, 0: active low).
- R6: With `coast_sel_vs`=1, `coast` is 1 while the vertical sync source is active. `vs_sel_sep`=1 picks the separator output and `vs_sel_sep`=0 picks the polarity-corrected `vs_in`. The source that is not selected has no effect.
- R7: Leading edges of horizontal sync are counted from each vertical sync onset. The count at the next onset becomes the frame length L. After two onsets have been seen, `coast` rises once the line count reaches L - `pre_lines`. A `pre_lines` of 0 opens no early window.
- R8: After the vertical sync source falls, `coast` stays at 1 until `post_lines` further leading edges have passed and drops at the last of them. A `post_lines` of 0 lets `coast` drop with vertical sync.
- R9: `sync_act` bits {2:sync-on-green, 1:vertical, 0:horizontal} go to 1 on any edge of their input. Each bit clears after `ACT_WIN` clocks pass with no edge.
- R10: `sync_pol` bits {2:coast pin, 1:vertical, 0:horizontal} are updated at each rising edge of their input. A bit is 1 when the high time of the period just ended was shorter than its low time, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_5m | input | 1 | One-cycle pulse every 200 ns |
| hs_in | input | 1 | Horizontal or composite sync |
| vs_in | input | 1 | Vertical sync pin |
| sog_in | input | 1 | Sync-on-green slicer output (activity only) |
| coast_pin | input | 1 | External coast request |
| sep_thresh | input | TH_W | Broad-pulse threshold in ticks |
| pre_lines | input | CNT_W | Lines of coast before vertical sync |
| post_lines | input | CNT_W | Lines of coast after vertical sync |
| vs_sel_sep | input | 1 | Vertical source: 1 separator, 0 pin |
| coast_sel_vs | input | 1 | Coast source: 1 vertical window, 0 pin |
| coast_pol | input | 1 | Coast pin active level |
| sep_vs | output | 1 | Separated vertical sync |
| coast | output | 1 | Coast to the clock loop |
| sync_act | output | 3 | Activity flags |
| sync_pol | output | 3 | Detected polarities |

## Verification
The bench builds the block with `ACT_WIN` set to 256, so an idle input loses its activity flag within a few hundred clocks while 200-clock lines keep it set. All other parameters keep their defaults: 8-bit threshold and line counts, an 11-bit line counter and 12-bit polarity counters, which is enough for the 20-line frames and 4000-clock vertical periods used. The 20-clock line pulses always span exactly two ticks, so thresholds of 1 and 2 probe the exact boundary of the width comparison.

// File: rtl/csc_pkg.sv
package csc_pkg;
    // vertical sync source feeding the coast window
    typedef enum logic {VSRC_PIN = 1'b0, VSRC_SEP = 1'b1} vsrc_sel_e;
    // coast output source
    typedef enum logic {CST_PIN = 1'b0, CST_VSYNC = 1'b1} cst_sel_e;
endpackage

// File: rtl/act_mon.sv
module act_mon #(
    parameter int WIN = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic act
);
    localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;

    typedef struct packed {
        logic          prev;
        logic          act;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = sig;
        if (sig != s_q.prev) begin
            s_d.act = 1'b1;
            s_d.cnt = '0;
        end else if (s_q.cnt == CW'(WIN - 1)) begin
            s_d.act = 1'b0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act = s_q.act;
endmodule

// File: rtl/pol_mon.sv
module pol_mon #(
    parameter int CW = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic pol
);
    typedef struct packed {
        logic          prev;
        logic          pol;
        logic [CW-1:0] hi;
        logic [CW-1:0] lo;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = sig;
        if (sig && !s_q.prev) begin
            // period closed: the shorter level is the pulse
            s_d.pol = (s_q.hi < s_q.lo);
            s_d.hi  = CW'(1);
            s_d.lo  = '0;
        end else if (sig) begin
            if (s_q.hi != '1) s_d.hi = s_q.hi + 1'b1;
        end else begin
            if (s_q.lo != '1) s_d.lo = s_q.lo + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{prev: 1'b0, pol: 1'b1, hi: '0, lo: '0};
        else        s_q <= s_d;
    end

    assign pol = s_q.pol;
endmodule

// File: rtl/sep_width.sv
module sep_width #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          lvl,
    input  logic [TW-1:0] thresh,
    output logic          vs
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          vs;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!lvl) begin
            s_d.cnt = '0;
        end else if (tick && s_q.cnt != '1) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.vs = lvl && (s_d.cnt > thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign vs = s_q.vs;
endmodule

// File: rtl/coast_gen.sv
module coast_gen #(
    parameter int LW = 11,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_lvl,
    input  logic          vsrc,
    input  logic [PW-1:0] pre,
    input  logic [PW-1:0] post,
    output logic          win
);
    typedef struct packed {
        logic          hs_prev;
        logic          vs_prev;
        logic [LW-1:0] line_cnt;
        logic [LW-1:0] frame_len;
        logic          seen;
        logic          ok;
        logic          pre_win;
        logic          post_win;
        logic [PW-1:0] post_cnt;
        logic          win;
    } st_t;

    st_t  s_d, s_q;
    logic lead, vrise, vfall;

    always_comb begin
        lead      = hs_lvl && !s_q.hs_prev;
        vrise     = vsrc && !s_q.vs_prev;
        vfall     = !vsrc && s_q.vs_prev;
        s_d       = s_q;
        s_d.hs_prev = hs_lvl;
        s_d.vs_prev = vsrc;
        if (vrise) begin
            s_d.frame_len = s_q.line_cnt;
            s_d.ok        = s_q.seen;
            s_d.seen      = 1'b1;
            s_d.line_cnt  = '0;
            s_d.pre_win   = 1'b0;
            s_d.post_win  = 1'b0;
        end else begin
            if (lead && s_q.line_cnt != '1) s_d.line_cnt = s_q.line_cnt + 1'b1;
            if (s_q.ok && pre != '0 && LW'(pre) <= s_q.frame_len &&
                s_q.line_cnt >= s_q.frame_len - LW'(pre))
                s_d.pre_win = 1'b1;
            if (vfall) begin
                s_d.post_win = (post != '0);
                s_d.post_cnt = '0;
            end else if (s_q.post_win && lead) begin
                s_d.post_cnt = s_q.post_cnt + 1'b1;
                if (s_q.post_cnt + PW'(1) >= post) s_d.post_win = 1'b0;
            end
        end
        s_d.win = s_d.pre_win || s_d.post_win || vsrc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign win = s_q.win;
endmodule

// File: rtl/csync_coast.sv
module csync_coast
    import csc_pkg::*;
#(
    parameter int TH_W    = 8,
    parameter int LINE_W  = 11,
    parameter int CNT_W   = 8,
    parameter int ACT_WIN = 8192,
    parameter int POL_W   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_5m,
    input  logic             hs_in,
    input  logic             vs_in,
    input  logic             sog_in,
    input  logic             coast_pin,
    input  logic [TH_W-1:0]  sep_thresh,
    input  logic [CNT_W-1:0] pre_lines,
    input  logic [CNT_W-1:0] post_lines,
    input  logic             vs_sel_sep,
    input  logic             coast_sel_vs,
    input  logic             coast_pol,
    output logic             sep_vs,
    output logic             coast,
    output logic [2:0]       sync_act,
    output logic [2:0]       sync_pol
);
    localparam int NMON = 3;

    logic [NMON-1:0] act_src, pol_src;
    logic            hs_lvl, vs_lvl, vsrc, win;
    logic            pin_d, pin_q;
    vsrc_sel_e       vsel;
    cst_sel_e        csel;

    assign act_src = {sog_in, vs_in, hs_in};
    assign pol_src = {coast_pin, vs_in, hs_in};

    for (genvar i = 0; i < NMON; i++) begin : g_mon
        act_mon #(.WIN(ACT_WIN)) u_act (
            .clk(clk), .rst_n(rst_n), .sig(act_src[i]), .act(sync_act[i])
        );
        pol_mon #(.CW(POL_W)) u_pol (
            .clk(clk), .rst_n(rst_n), .sig(pol_src[i]), .pol(sync_pol[i])
        );
    end

    assign hs_lvl = sync_pol[0] ? hs_in : !hs_in;
    assign vs_lvl = sync_pol[1] ? vs_in : !vs_in;
    assign vsel   = vsrc_sel_e'(vs_sel_sep);
    assign csel   = cst_sel_e'(coast_sel_vs);
    assign vsrc   = (vsel == VSRC_SEP) ? sep_vs : vs_lvl;

    sep_width #(.TW(TH_W)) u_sep (
        .clk(clk), .rst_n(rst_n), .tick(tick_5m), .lvl(hs_lvl),
        .thresh(sep_thresh), .vs(sep_vs)
    );

    coast_gen #(.LW(LINE_W), .PW(CNT_W)) u_cg (
        .clk(clk), .rst_n(rst_n), .hs_lvl(hs_lvl), .vsrc(vsrc),
        .pre(pre_lines), .post(post_lines), .win(win)
    );

    always_comb pin_d = (coast_pin == coast_pol);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign coast = (csel == CST_VSYNC) ? win : pin_q;
endmodule

// File: rtl/csync_coast_chk.sv
module csync_coast_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_in,
    input logic       hs_lvl,
    input logic       vsrc,
    input logic       coast_sel_vs,
    input logic       coast_pin,
    input logic       coast_pol,
    input logic       coast,
    input logic       sep_vs,
    input logic [2:0] sync_act
);
    // R2: the separated vertical sync only follows a cycle at active level
    a_r2_sep_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
        sep_vs |-> $past(hs_lvl));

    // R5: pin path is the pin compared with its polarity, one clock late
    a_r5_pin_path: assert property (@(posedge clk) disable iff (!rst_n)
        (!coast_sel_vs && $past(rst_n)) |-> (coast == $past(coast_pin == coast_pol)));

    // R6: an active vertical source always yields coast on the next clock
    a_r6_vsync_coasts: assert property (@(posedge clk) disable iff (!rst_n)
        (coast_sel_vs && $past(vsrc) && $past(rst_n)) |-> coast);

    // R9: horizontal activity only falls after a quiet clock
    a_r9_act_falls_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_act[0]) |-> ($past(hs_in) == $past(hs_in, 2)));
endmodule

bind csync_coast csync_coast_chk u_chk (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .hs_lvl(hs_lvl), .vsrc(vsrc),
    .coast_sel_vs(coast_sel_vs), .coast_pin(coast_pin), .coast_pol(coast_pol),
    .coast(coast), .sep_vs(sep_vs), .sync_act(sync_act)
);

// File: tb/csync_coast_tb.sv
module csync_coast_tb;
    localparam int LINE_T = 200;
    localparam int NLINES = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_5m = 1'b0;
    logic       hs_in = 1'b0, vs_in = 1'b0, sog_in = 1'b0, coast_pin = 1'b0;
    logic [7:0] sep_thresh = 8'd4, pre_lines = 8'd0, post_lines = 8'd0;
    logic       vs_sel_sep = 1'b1, coast_sel_vs = 1'b1, coast_pol = 1'b1;
    logic       sep_vs, coast;
    logic [2:0] sync_act, sync_pol;

    int n_chk = 0, n_fail = 0, tick_div = 0, cyc = 0;
    logic sep_seen = 1'b0;

    csync_coast #(.ACT_WIN(256)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_5m(tick_5m), .hs_in(hs_in), .vs_in(vs_in),
        .sog_in(sog_in), .coast_pin(coast_pin), .sep_thresh(sep_thresh),
        .pre_lines(pre_lines), .post_lines(post_lines), .vs_sel_sep(vs_sel_sep),
        .coast_sel_vs(coast_sel_vs), .coast_pol(coast_pol), .sep_vs(sep_vs),
        .coast(coast), .sync_act(sync_act), .sync_pol(sync_pol)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tick_div = (tick_div == 9) ? 0 : tick_div + 1;
        tick_5m  = (tick_div == 0);
        if (sep_vs) sep_seen = 1'b1;
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic line_start(input int w, input logic inv);
        hs_in = ~inv;
        repeat (w) @(negedge clk);
        hs_in = inv;
    endtask

    task automatic line_rest(input int w);
        repeat (LINE_T - w) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 sep_vs", {7'd0, sep_vs}, 8'd0);
        chk("R1 coast", {7'd0, coast}, 8'd0);
        chk("R1 sync_act", {5'd0, sync_act}, 8'd0);
        chk("R1 sync_pol", {5'd0, sync_pol}, 8'h7);
    endtask

    task automatic t_sep_thresh();
        // a 20-clock pulse spans exactly two ticks
        sep_thresh = 8'd1; sep_seen = 1'b0;
        line_start(20, 1'b0); line_rest(20);
        chk("R2 two ticks over threshold 1", {7'd0, sep_seen}, 8'd1);
        sep_thresh = 8'd2; sep_seen = 1'b0;
        line_start(20, 1'b0); line_rest(20);
        chk("R3 two ticks at threshold 2", {7'd0, sep_seen}, 8'd0);
        sep_thresh = 8'd4;
    endtask

    task automatic t_composite();
        pre_lines = 8'd3; post_lines = 8'd2;
        for (int f = 0; f < 4; f++) begin
            for (int j = 0; j < NLINES; j++) begin
                line_start(j == 0 ? 80 : 20, 1'b0);
                if (f == 2 && j == 16) chk("R7 before pre window", {7'd0, coast}, 8'd0);
                if (f == 2 && j == 17) chk("R7 pre window open", {7'd0, coast}, 8'd1);
                if (f == 3 && j == 0) begin
                    chk("R2 broad pulse separated", {7'd0, sep_vs}, 8'd1);
                    chk("R6 coast during vsync", {7'd0, coast}, 8'd1);
                end
                if (f == 3 && j == 1) chk("R8 post window line 1", {7'd0, coast}, 8'd1);
                if (f == 3 && j == 2) chk("R8 post window closed", {7'd0, coast}, 8'd0);
                if (f == 3 && j == 10) begin
                    chk("R7 mid frame idle", {7'd0, coast}, 8'd0);
                    chk("R9 hs active", {7'd0, sync_act[0]}, 8'd1);
                end
                line_rest(j == 0 ? 80 : 20);
            end
        end
    endtask

    task automatic t_zero_windows();
        pre_lines = 8'd0; post_lines = 8'd0;
        for (int f = 0; f < 3; f++) begin
            for (int j = 0; j < NLINES; j++) begin
                line_start(j == 0 ? 80 : 20, 1'b0);
                if (f == 1 && j == 18) chk("R7 zero pre lines", {7'd0, coast}, 8'd0);
                if (f == 2 && j == 0) chk("R6 coast with vsync only", {7'd0, coast}, 8'd1);
                if (f == 2 && j == 1) chk("R8 zero post lines", {7'd0, coast}, 8'd0);
                line_rest(j == 0 ? 80 : 20);
            end
        end
    endtask

    task automatic t_vs_pin();
        vs_sel_sep = 1'b0;
        for (int f = 0; f < 2; f++) begin
            for (int j = 0; j < NLINES; j++) begin
                if (j == 0) vs_in = 1'b1;
                if (j == 2) vs_in = 1'b0;
                line_start((f == 1 && j == 10) ? 80 : 20, 1'b0);
                if (f == 1 && j == 0) chk("R9 vs active", {7'd0, sync_act[1]}, 8'd1);
                if (f == 1 && j == 1) chk("R6 vs pin drives coast", {7'd0, coast}, 8'd1);
                if (f == 1 && j == 4) chk("R6 vs pin released", {7'd0, coast}, 8'd0);
                if (f == 1 && j == 10) begin
                    chk("R2 broad pulse still separated", {7'd0, sep_vs}, 8'd1);
                    chk("R6 separator ignored when pin selected", {7'd0, coast}, 8'd0);
                end
                line_rest((f == 1 && j == 10) ? 80 : 20);
            end
        end
        chk("R10 vs polarity high", {7'd0, sync_pol[1]}, 8'd1);
        vs_sel_sep = 1'b1;
    endtask

    task automatic t_pin();
        coast_sel_vs = 1'b0;
        coast_pol = 1'b1; coast_pin = 1'b1; repeat (3) @(negedge clk);
        chk("R5 active-high pin asserted", {7'd0, coast}, 8'd1);
        coast_pin = 1'b0; repeat (3) @(negedge clk);
        chk("R5 active-high pin idle", {7'd0, coast}, 8'd0);
        coast_pol = 1'b0; repeat (3) @(negedge clk);
        chk("R5 active-low pin asserted", {7'd0, coast}, 8'd1);
        coast_pin = 1'b1; repeat (3) @(negedge clk);
        chk("R5 active-low pin idle", {7'd0, coast}, 8'd0);
        for (int k = 0; k < 4; k++) begin
            coast_pin = 1'b0; repeat (10) @(negedge clk);
            coast_pin = 1'b1; repeat (90) @(negedge clk);
        end
        chk("R10 coast pin polarity low", {7'd0, sync_pol[2]}, 8'd0);
        coast_sel_vs = 1'b1;
    endtask

    task automatic t_hs_inverted();
        for (int k = 0; k < 3; k++) begin
            line_start(20, 1'b1); line_rest(20);
        end
        chk("R10 hs polarity low", {7'd0, sync_pol[0]}, 8'd0);
        line_start(80, 1'b1);
        chk("R4 low broad pulse separated", {7'd0, sep_vs}, 8'd1);
        line_rest(80);
    endtask

    task automatic t_activity();
        repeat (300) @(negedge clk);
        chk("R9 all idle", {5'd0, sync_act}, 8'd0);
        sog_in = 1'b1; repeat (3) @(negedge clk);
        chk("R9 sog edge seen", {5'd0, sync_act}, 8'h4);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_sep_thresh();
        t_composite();
        t_zero_windows();
        t_vs_pin();
        t_pin();
        t_hs_inverted();
        t_activity();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule